// File: doc/BRIEF.md
# Virtually Indexed Physically Tagged Tag Lookup with Alias Resolution

This block holds the tag and valid state of a 64 KB, 2-way, 64-byte-line L1 data cache whose set index is taken from the virtual address. A lookup presents the virtual address and, in the same cycle, the physical page number produced by an external translation unit. The tag array is read with the virtual index while translation completes, and the stored physical page numbers are compared against the translated one.

Because a way spans 32 KB and a page only 4 KB, three index bits come from the virtual page number. A physical line may therefore sit in any of eight sets, depending on the translation used when it was filled. On a miss in the indexed set, the block walks the seven other candidate sets one per cycle, invalidates any copy it finds, and reports the old location so the data side can move the line. The block keeps one copy per physical line. It raises a machine-check pulse when it finds more than one copy. A fill port writes a tag after a true miss. A second port removes a physical line from all eight candidate sets.

Top module: `vipt_tag_lookup`

## Requirements
- R1: After reset every entry is invalid. `busy_o`, `resp_valid_o`, `fill_done_o`, `inv_done_o` and `mce_o` are low, and any lookup ends as a true miss.
- R2: The set index is `req_vaddr_i[14:6]` and the stored tag is the physical page number. A lookup whose `tlb_ppn_i` equals a valid tag in the indexed set raises `resp_valid_o` with `resp_hit_o` one cycle after the request. It reports that set on `resp_set_o` and the matching way on `resp_way_o`, with way 0 preferred.
- R3: On a miss in the indexed set, `busy_o` rises and the seven other sets with the same `req_vaddr_i[11:6]` are visited in ascending order of the three alias bits (set bits 8:6), one per cycle. The response arrives on the eighth clock edge after the request edge. Requests presented while `busy_o` is high are ignored and get no response.
- R4: If a candidate set holds the physical page number, the response carries `resp_alias_o`. `resp_set_o` and `resp_way_o` give the first match (lowest alias first, then lowest way), and that entry is invalidated.
- R5: When no candidate matches, the response carries `resp_miss_o` and `resp_set_o` is the indexed set.
- R6: `mce_o` pulses with the response when both ways of the indexed set match, or when more than one entry matches during an alias search. Every matching entry found by the search is invalidated.
- R7: `fill_valid_i` writes `fill_ppn_i` into set `fill_set_i`. The way is the lowest invalid way, or a pseudo-random way when all ways are valid. `fill_done_o` and `fill_way_o` report the write one cycle later.
- R8: `inv_valid_i` removes the physical line {`inv_ppn_i`, `inv_line_i`} from all eight candidate sets. `busy_o` stays high for eight cycles, and `inv_done_o` pulses on the ninth edge with `inv_hit_o` set if anything was cleared. `mce_o` pulses with it if more than one entry was cleared.
- R9: When the block is idle and several commands arrive in one cycle, fill wins over invalidate and invalidate wins over lookup. The losing commands are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 32 | Virtual address of lookup |
| tlb_ppn_i | input | 20 | Translated page number, same cycle as request |
| fill_valid_i | input | 1 | Tag write command |
| fill_set_i | input | 9 | Set to fill |
| fill_ppn_i | input | 20 | Page number to store |
| inv_valid_i | input | 1 | Invalidate-by-physical-line command |
| inv_ppn_i | input | 20 | Page number of line to remove |
| inv_line_i | input | 6 | Line-in-page bits of line to remove |
| busy_o | output | 1 | Sequential search in progress |
| resp_valid_o | output | 1 | Lookup response strobe |
| resp_hit_o | output | 1 | Hit in indexed set |
| resp_alias_o | output | 1 | Copy found in another candidate set |
| resp_miss_o | output | 1 | No copy anywhere |
| resp_set_o | output | 9 | Hit set, old alias set, or indexed set on miss |
| resp_way_o | output | 1 | Hit or old alias way |
| mce_o | output | 1 | Multiple-copy machine check |
| fill_done_o | output | 1 | Fill acknowledge |
| fill_way_o | output | 1 | Way written by fill |
| inv_done_o | output | 1 | Invalidate finished |
| inv_hit_o | output | 1 | Invalidate cleared an entry |

## Verification
The hardest state to reach is a line present in two places at once. A correct lookup and fill sequence never creates it, so no lookup alone can produce the multiple-copy error. The stimulus builds it on purpose by filling the same page number into two alias sets that share line bits, or twice into one set so that both ways hold it. Lookups and invalidates then run against that state. Random phases draw from four page numbers and four line-in-page values, so alias collisions and duplicates keep recurring.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SRCH = 2'd1,
    ST_INV  = 2'd2
  } vipt_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int SET_W = 9,
  parameter int WAYS  = 2,
  parameter int TAG_W = 20,
  localparam int SETS  = 1 << SET_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [SET_W-1:0]            rd_set_i,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag_o,
  output logic [WAYS-1:0]             rd_vld_o,
  input  logic                        wr_en_i,
  input  logic [SET_W-1:0]            wr_set_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic [TAG_W-1:0]            wr_tag_i,
  input  logic [WAYS-1:0]             clr_i
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic             vld_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS];
    logic             wr_here;

    assign wr_here     = wr_en_i && (wr_way_i == WAY_W'(w));
    assign rd_vld_o[w] = vld_q[rd_set_i];
    assign rd_tag_o[w] = tag_q[rd_set_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) vld_q[s] <= 1'b0;
      end else if (wr_here) begin
        vld_q[wr_set_i] <= 1'b1;
      end else if (clr_i[w]) begin
        vld_q[rd_set_i] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i) begin
      if (wr_here) tag_q[wr_set_i] <= wr_tag_i;
    end
  end
endmodule

// File: rtl/vipt_way_cmp.sv
module vipt_way_cmp #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [WAYS-1:0]            vld_i,
  input  logic [TAG_W-1:0]           key_i,
  output logic [WAYS-1:0]            match_o,
  output logic                       any_o,
  output logic                       multi_o,
  output logic [WAY_W-1:0]           first_o
);
  logic [WAY_W:0] cnt;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = vld_i[w] && (tag_i[w] == key_i);
  end

  always_comb begin
    cnt     = '0;
    first_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_o[w]) first_o = WAY_W'(w);
    end
    for (int w = 0; w < WAYS; w++) cnt = cnt + (WAY_W+1)'(match_o[w]);
  end

  assign any_o   = |match_o;
  assign multi_o = cnt > (WAY_W+1)'(1);
endmodule

// File: rtl/vipt_victim_sel.sv
module vipt_victim_sel #(
  parameter int WAYS = 2,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WAYS-1:0]  vld_i,
  output logic [WAY_W-1:0] way_o
);
  logic [7:0] lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= 8'h5a;
    else         lfsr_q <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
  end

  // empty way first, random only when the set is full
  always_comb begin
    way_o = lfsr_q[WAY_W-1:0];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/vipt_tag_lookup.sv
module vipt_tag_lookup
  import vipt_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PPN_W  = 20,
  parameter int SET_W  = 9,
  parameter int WAYS   = 2,
  parameter int LINE_W = 6,
  parameter int PAGE_W = 12,
  localparam int ALIAS_W = SET_W + LINE_W - PAGE_W,
  localparam int NALIAS  = 1 << ALIAS_W,
  localparam int LO_W    = PAGE_W - LINE_W,
  localparam int WAY_W   = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [PPN_W-1:0]  tlb_ppn_i,
  input  logic              fill_valid_i,
  input  logic [SET_W-1:0]  fill_set_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic              inv_valid_i,
  input  logic [PPN_W-1:0]  inv_ppn_i,
  input  logic [LO_W-1:0]   inv_line_i,
  output logic              busy_o,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_alias_o,
  output logic              resp_miss_o,
  output logic [SET_W-1:0]  resp_set_o,
  output logic [WAY_W-1:0]  resp_way_o,
  output logic              mce_o,
  output logic              fill_done_o,
  output logic [WAY_W-1:0]  fill_way_o,
  output logic              inv_done_o,
  output logic              inv_hit_o
);
  localparam logic [ALIAS_W-1:0] LAST_SRCH = ALIAS_W'(NALIAS - 2);
  localparam logic [ALIAS_W-1:0] LAST_INV  = ALIAS_W'(NALIAS - 1);

  vipt_state_e          state_q;
  logic [ALIAS_W-1:0]   vis_q, prim_q, cur_alias;
  logic [LO_W-1:0]      lo_q;
  logic [PPN_W-1:0]     key_q, key;
  logic                 fnd_q, multi_q, fnd_n, multi_n, last_vis;
  logic [SET_W-1:0]     fset_q, fset_n, rd_set, req_set;
  logic [WAY_W-1:0]     fway_q, fway_n, victim, first;
  logic [WAYS-1:0][PPN_W-1:0] rd_tag;
  logic [WAYS-1:0]      rd_vld, match, clr;
  logic                 any, multi;
  logic                 unused_va;

  assign unused_va = ^{req_vaddr_i[VA_W-1:LINE_W+SET_W], req_vaddr_i[LINE_W-1:0]};
  assign req_set   = req_vaddr_i[LINE_W +: SET_W];
  assign busy_o    = (state_q != ST_IDLE);

  // search order skips the primary alias
  always_comb begin
    if (state_q == ST_INV || vis_q < prim_q) cur_alias = vis_q;
    else                                     cur_alias = vis_q + 1'b1;
  end

  always_comb begin
    if (state_q == ST_IDLE) begin
      rd_set = fill_valid_i ? fill_set_i : req_set;
      key    = tlb_ppn_i;
    end else begin
      rd_set = {cur_alias, lo_q};
      key    = key_q;
    end
  end

  assign last_vis = (state_q == ST_SRCH) ? (vis_q == LAST_SRCH) : (vis_q == LAST_INV);
  assign clr      = busy_o ? match : '0;

  vipt_tag_store #(.SET_W(SET_W), .WAYS(WAYS), .TAG_W(PPN_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_set_i (rd_set),
    .rd_tag_o (rd_tag),
    .rd_vld_o (rd_vld),
    .wr_en_i  (state_q == ST_IDLE && fill_valid_i),
    .wr_set_i (fill_set_i),
    .wr_way_i (victim),
    .wr_tag_i (fill_ppn_i),
    .clr_i    (clr)
  );

  vipt_way_cmp #(.WAYS(WAYS), .TAG_W(PPN_W)) u_cmp (
    .tag_i   (rd_tag),
    .vld_i   (rd_vld),
    .key_i   (key),
    .match_o (match),
    .any_o   (any),
    .multi_o (multi),
    .first_o (first)
  );

  vipt_victim_sel #(.WAYS(WAYS)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (rd_vld),
    .way_o  (victim)
  );

  always_comb begin
    fnd_n   = fnd_q | any;
    multi_n = multi_q | multi | (fnd_q & any);
    fset_n  = fset_q;
    fway_n  = fway_q;
    if (!fnd_q && any) begin
      fset_n = rd_set;
      fway_n = first;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      vis_q        <= '0;
      prim_q       <= '0;
      lo_q         <= '0;
      key_q        <= '0;
      fnd_q        <= 1'b0;
      multi_q      <= 1'b0;
      fset_q       <= '0;
      fway_q       <= '0;
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_alias_o <= 1'b0;
      resp_miss_o  <= 1'b0;
      resp_set_o   <= '0;
      resp_way_o   <= '0;
      mce_o        <= 1'b0;
      fill_done_o  <= 1'b0;
      fill_way_o   <= '0;
      inv_done_o   <= 1'b0;
      inv_hit_o    <= 1'b0;
    end else begin
      resp_valid_o <= 1'b0;
      mce_o        <= 1'b0;
      fill_done_o  <= 1'b0;
      inv_done_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          fnd_q   <= 1'b0;
          multi_q <= 1'b0;
          vis_q   <= '0;
          if (fill_valid_i) begin
            fill_done_o <= 1'b1;
            fill_way_o  <= victim;
          end else if (inv_valid_i) begin
            state_q <= ST_INV;
            lo_q    <= inv_line_i;
            key_q   <= inv_ppn_i;
          end else if (req_valid_i) begin
            if (any) begin
              resp_valid_o <= 1'b1;
              resp_hit_o   <= 1'b1;
              resp_alias_o <= 1'b0;
              resp_miss_o  <= 1'b0;
              resp_set_o   <= req_set;
              resp_way_o   <= first;
              mce_o        <= multi;
            end else begin
              state_q <= ST_SRCH;
              prim_q  <= req_set[SET_W-1 -: ALIAS_W];
              lo_q    <= req_set[LO_W-1:0];
              key_q   <= tlb_ppn_i;
            end
          end
        end
        ST_SRCH, ST_INV: begin
          fnd_q   <= fnd_n;
          multi_q <= multi_n;
          fset_q  <= fset_n;
          fway_q  <= fway_n;
          vis_q   <= vis_q + 1'b1;
          if (last_vis) begin
            state_q <= ST_IDLE;
            mce_o   <= multi_n;
            if (state_q == ST_SRCH) begin
              resp_valid_o <= 1'b1;
              resp_hit_o   <= 1'b0;
              resp_alias_o <= fnd_n;
              resp_miss_o  <= !fnd_n;
              resp_set_o   <= fnd_n ? fset_n : {prim_q, lo_q};
              resp_way_o   <= fnd_n ? fway_n : '0;
            end else begin
              inv_done_o <= 1'b1;
              inv_hit_o  <= fnd_n;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vipt_tag_lookup_chk.sv
module vipt_tag_lookup_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic resp_valid_o,
  input logic resp_hit_o,
  input logic resp_alias_o,
  input logic resp_miss_o,
  input logic mce_o,
  input logic fill_valid_i,
  input logic fill_done_o,
  input logic inv_done_o
);
  assert_resp_kind_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $onehot({resp_hit_o, resp_alias_o, resp_miss_o}));

  assert_resp_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !busy_o);

  assert_search_multi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);

  assert_mce_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mce_o |-> (resp_valid_o || inv_done_o));

  assert_fill_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_o |-> ($past(fill_valid_i) && !$past(busy_o)));

  assert_inv_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_done_o |-> (!busy_o && $past(busy_o)));

  assert_fill_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_o |-> (!resp_valid_o && !inv_done_o));
endmodule

bind vipt_tag_lookup vipt_tag_lookup_chk u_chk (.*);

// File: tb/vipt_tag_lookup_test.sv
module vipt_tag_lookup_test;
  localparam int VA_W = 32, PPN_W = 20, SET_W = 9, WAYS = 2, LINE_W = 6, PAGE_W = 12;
  localparam int SETS = 1 << SET_W;
  localparam int LO_N = 1 << (PAGE_W - LINE_W);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, fill_valid_i = 1'b0, inv_valid_i = 1'b0;
  logic [VA_W-1:0]  req_vaddr_i = '0;
  logic [PPN_W-1:0] tlb_ppn_i = '0, fill_ppn_i = '0, inv_ppn_i = '0;
  logic [SET_W-1:0] fill_set_i = '0;
  logic [5:0]       inv_line_i = '0;
  logic busy_o, resp_valid_o, resp_hit_o, resp_alias_o, resp_miss_o, mce_o;
  logic fill_done_o, inv_done_o, inv_hit_o;
  logic [SET_W-1:0] resp_set_o;
  logic resp_way_o, fill_way_o;

  always #4 clk_i = ~clk_i;

  vipt_tag_lookup uut (.*);

  int checks = 0, errors = 0;
  bit mv [SETS][WAYS];
  logic [PPN_W-1:0] mt [SETS][WAYS];

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] mk_va(input int al, input int lo);
    logic [VA_W-1:0] v;
    v = $urandom;
    v[LINE_W +: SET_W] = SET_W'(al * LO_N + lo);
    return v;
  endfunction

  // expected outcome of a lookup; updates the model
  task automatic exp_req(input logic [VA_W-1:0] va, input logic [PPN_W-1:0] pp,
                         output int kind, output int eset, output int eway, output bit emce);
    int ps, pa, lo, cnt;
    bit m0, m1;
    ps = int'(va[LINE_W +: SET_W]);
    pa = ps / LO_N;
    lo = ps % LO_N;
    cnt = 0; eway = 0; eset = ps; emce = 0;
    m0 = mv[ps][0] && mt[ps][0] == pp;
    m1 = mv[ps][1] && mt[ps][1] == pp;
    if (m0 || m1) begin
      kind = 0; eway = m0 ? 0 : 1; emce = m0 && m1;
    end else begin
      kind = 2;
      for (int a = 0; a < 8; a++) begin
        if (a != pa) begin
          for (int w = 0; w < WAYS; w++) begin
            int s;
            s = a * LO_N + lo;
            if (mv[s][w] && mt[s][w] == pp) begin
              if (cnt == 0) begin eset = s; eway = w; end
              cnt++;
              mv[s][w] = 1'b0;
            end
          end
        end
      end
      if (cnt > 0) kind = 1;
      emce = cnt > 1;
    end
  endtask

  task automatic do_req(input logic [VA_W-1:0] va, input logic [PPN_W-1:0] pp, input string rq);
    int kind, eset, eway, n;
    bit emce;
    exp_req(va, pp, kind, eset, eway, emce);
    req_valid_i = 1'b1; req_vaddr_i = va; tlb_ppn_i = pp;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    n = 1;
    if (kind != 0) chk(rq, "busy", busy_o, 1);
    while (!resp_valid_o && n < 20) begin @(negedge clk_i); n++; end
    chk(rq, "latency", n, (kind == 0) ? 1 : 8);
    chk(rq, "hit", resp_hit_o, kind == 0);
    chk(rq, "alias", resp_alias_o, kind == 1);
    chk(rq, "miss", resp_miss_o, kind == 2);
    chk(rq, "set", resp_set_o, eset);
    if (kind != 2) chk(rq, "way", resp_way_o, eway);
    chk(rq, "mce", mce_o, emce);
  endtask

  task automatic do_fill(input int set, input logic [PPN_W-1:0] pp, input string rq);
    int ew, w;
    ew = -1;
    for (int i = WAYS - 1; i >= 0; i--) if (!mv[set][i]) ew = i;
    fill_valid_i = 1'b1; fill_set_i = SET_W'(set); fill_ppn_i = pp;
    @(negedge clk_i);
    fill_valid_i = 1'b0;
    chk(rq, "fill_done", fill_done_o, 1);
    if (ew >= 0) chk(rq, "fill_way", fill_way_o, ew);
    w = int'(fill_way_o);
    mv[set][w] = 1'b1;
    mt[set][w] = pp;
  endtask

  task automatic do_inv(input logic [PPN_W-1:0] pp, input int lo, input string rq);
    int cnt, n;
    cnt = 0;
    for (int a = 0; a < 8; a++)
      for (int w = 0; w < WAYS; w++) begin
        int s;
        s = a * LO_N + lo;
        if (mv[s][w] && mt[s][w] == pp) begin cnt++; mv[s][w] = 1'b0; end
      end
    inv_valid_i = 1'b1; inv_ppn_i = pp; inv_line_i = 6'(lo);
    @(negedge clk_i);
    inv_valid_i = 1'b0;
    n = 1;
    while (!inv_done_o && n < 20) begin @(negedge clk_i); n++; end
    chk(rq, "inv_latency", n, 9);
    chk(rq, "inv_hit", inv_hit_o, cnt > 0);
    chk(rq, "inv_mce", mce_o, cnt > 1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk_i); cyc++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VA_W-1:0] va;
    int n, seen;
    void'($urandom(32'd2024));
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) begin mv[s][w] = 0; mt[s][w] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "resp_valid", resp_valid_o, 0);
    chk("R1", "fill_done", fill_done_o, 0);
    chk("R1", "inv_done", inv_done_o, 0);
    chk("R1", "mce", mce_o, 0);
    do_req(mk_va(3, 5), 20'h12345, "R1_R5 empty lookup");

    // plain hit, second entry in other way
    do_fill(2 * LO_N + 7, 20'h00a11, "R7 first fill");
    do_fill(2 * LO_N + 7, 20'h00b22, "R7 second fill");
    do_req(mk_va(2, 7), 20'h00a11, "R2 hit way0");
    do_req(mk_va(2, 7), 20'h00b22, "R2 hit way1");
    do_fill(2 * LO_N + 7, 20'h00c33, "R7 full set fill");

    // alias moved
    do_fill(5 * LO_N + 9, 20'h0d000, "R7 alias src");
    do_req(mk_va(1, 9), 20'h0d000, "R4 alias found");
    do_req(mk_va(5, 9), 20'h0d000, "R4 old copy gone");

    // two alias copies
    do_fill(2 * LO_N + 11, 20'h0e000, "R6 dup a");
    do_fill(6 * LO_N + 11, 20'h0e000, "R6 dup b");
    do_req(mk_va(0, 11), 20'h0e000, "R6 multi alias");
    do_req(mk_va(6, 11), 20'h0e000, "R6 both cleared");

    // both ways of indexed set
    do_fill(4 * LO_N + 1, 20'h0f000, "R6 same set a");
    do_fill(4 * LO_N + 1, 20'h0f000, "R6 same set b");
    do_req(mk_va(4, 1), 20'h0f000, "R6 primary double");

    // invalidate
    do_fill(1 * LO_N + 3, 20'h01234, "R8 copy a");
    do_fill(7 * LO_N + 3, 20'h01234, "R8 copy b");
    do_inv(20'h01234, 3, "R8 inv dup");
    do_inv(20'h01234, 3, "R8 inv absent");
    do_req(mk_va(7, 3), 20'h01234, "R8 after inv");

    // requests while busy are dropped
    do_fill(3 * LO_N + 20, 20'h05555, "R3 setup");
    va = mk_va(0, 21);
    req_valid_i = 1'b1; req_vaddr_i = va; tlb_ppn_i = 20'h07777;
    @(negedge clk_i);
    req_vaddr_i = mk_va(3, 20); tlb_ppn_i = 20'h05555;
    n = 1; seen = 0;
    repeat (3) begin @(negedge clk_i); n++; seen += resp_valid_o; end
    req_valid_i = 1'b0;
    while (!resp_valid_o && n < 20) begin @(negedge clk_i); n++; end
    chk("R3", "search latency", n, 8);
    chk("R3", "early resp", seen, 0);
    chk("R3", "miss", resp_miss_o, 1);
    seen = 0;
    repeat (3) begin @(negedge clk_i); seen += resp_valid_o; end
    chk("R3", "dropped request responses", seen, 0);

    // priority
    req_valid_i = 1'b1; req_vaddr_i = mk_va(3, 20); tlb_ppn_i = 20'h05555;
    fill_valid_i = 1'b1; fill_set_i = SET_W'(6 * LO_N + 30); fill_ppn_i = 20'h06060;
    @(negedge clk_i);
    req_valid_i = 1'b0; fill_valid_i = 1'b0;
    chk("R9", "fill_done", fill_done_o, 1);
    chk("R9", "req dropped", resp_valid_o, 0);
    mv[6 * LO_N + 30][int'(fill_way_o)] = 1'b1; mt[6 * LO_N + 30][int'(fill_way_o)] = 20'h06060;
    @(negedge clk_i);
    chk("R9", "req dropped later", resp_valid_o, 0);
    req_valid_i = 1'b1; inv_valid_i = 1'b1; inv_ppn_i = 20'h05555; inv_line_i = 6'd20;
    @(negedge clk_i);
    req_valid_i = 1'b0; inv_valid_i = 1'b0;
    chk("R9", "inv busy", busy_o, 1);
    n = 1; seen = 0;
    while (!inv_done_o && n < 20) begin @(negedge clk_i); n++; seen += resp_valid_o; end
    chk("R9", "inv hit", inv_hit_o, 1);
    chk("R9", "no lookup resp", seen, 0);
    for (int w = 0; w < WAYS; w++) if (mt[3 * LO_N + 20][w] == 20'h05555) mv[3 * LO_N + 20][w] = 1'b0;

    // random mix over a small pool
    for (int i = 0; i < 300; i++) begin
      int op, al, lo;
      logic [PPN_W-1:0] pp;
      op = $urandom_range(0, 9);
      al = $urandom_range(0, 7);
      lo = $urandom_range(0, 3);
      pp = 20'h0a000 + PPN_W'($urandom_range(0, 3));
      if (op < 4)      do_req(mk_va(al, lo), pp, "R4_R5 random lookup");
      else if (op < 8) do_fill(al * LO_N + lo, pp, "R7 random fill");
      else             do_inv(pp, lo, "R8 random inv");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule